// File: doc/BRIEF.md
# Byte-Stream Instruction Fetch Decoder

This block is the front end of a small 8-bit processor. It reads the program from a byte-wide memory, one byte per request, starting at its program counter. It gathers each instruction into an opcode byte and two operand bytes, and hands the result to the execute stage through a valid/ready handshake. The memory port has a read latency of one cycle: the byte for an address requested in one cycle arrives in the next.

Most opcodes take three bytes. The halt opcode takes one byte and stops the fetcher for good. An opcode byte that matches no defined operation traps the fetcher, which then stays stopped. The execute stage can redirect fetching with a taken-branch strobe and a target address. This discards whatever instruction was half gathered or waiting at the handshake. The opcode values of the ten three-byte operations come from a parameter table. Each operation also gets a small kind code, so the execute stage need not decode the opcode again.

Top module: `insn_fetch_seq`

## Requirements
- R1: A synchronous active-high reset sets pc to 0 and clears halted, illegal and dec_valid.
- R2: A read is requested by mem_rd_en high with mem_addr equal to pc. The byte is taken from mem_rdata in the following cycle, and pc advances by one in that same cycle, once per byte consumed.
- R3: A three-byte instruction is presented with dec_opcode as its first byte, dec_opa as its second byte (destination register index for register/register forms) and dec_opb as its third byte (source index). dec_pc is the address of its first byte.
- R4: dec_kind gives 0 for MOV (0x01), 1 for ADD (0x02), 2 for SUB (0x03), 3 for JMP (0x04), 4 for JZ (0x05), 5 for JNZ (0x06), 6 for CMP register/immediate (0x07), 7 for CMP register/register (0x09), 8 for MUL (0x0C) and 9 for DIV (0x0D).
- R5: While dec_valid is high and dec_ready is low, all decoded outputs hold steady and no memory read is issued. Fetching resumes only after the cycle in which dec_valid and dec_ready are both high.
- R6: An opcode byte of 0xFF (HLT) is one byte long. It raises halted, leaves pc one past it, presents no instruction and ends all further reads until reset.
- R7: An opcode byte outside the eleven defined values raises illegal, leaves pc one past it and ends all further reads and presentations until reset.
- R8: When br_taken is high and the fetcher is neither halted nor trapped, pc loads br_target in the next cycle. Any partial or presented instruction is dropped, even if dec_ready is high in the same cycle, and the next read goes to the target.
- R9: br_taken has no effect on pc, halted or illegal once halted or illegal is set.
- R10: pc wraps from its highest address to 0, and an instruction whose bytes span the wrap is gathered in address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rd_en | output | 1 | Read request for the byte at mem_addr |
| mem_addr | output | ADDR_W | Byte address of the read request |
| mem_rdata | input | 8 | Byte returned one cycle after a request |
| pc | output | ADDR_W | Address of the next byte to fetch |
| dec_valid | output | 1 | A decoded instruction is presented |
| dec_ready | input | 1 | Execute stage accepts the presented instruction |
| dec_opcode | output | 8 | Opcode byte |
| dec_kind | output | 4 | Operation kind code (see R4) |
| dec_opa | output | 8 | First operand byte |
| dec_opb | output | 8 | Second operand byte |
| dec_pc | output | ADDR_W | Address of the presented opcode byte |
| br_taken | input | 1 | Taken branch from the execute stage |
| br_target | input | ADDR_W | Address to fetch from after a taken branch |
| halted | output | 1 | HLT decoded; fetching stopped |
| illegal | output | 1 | Unknown opcode decoded; fetching stopped |

## Verification
The bench builds the block with ADDR_W = 8 and the default opcode table, against a full 256-byte program memory. With that width a branch to address 254 places a MUL across the wrap to address 0, and the byte found after it lands on an undefined opcode, so the wrap and the trap are reached in one run. Runs with an always-ready consumer, a random-ready consumer, a held-off consumer and branches both in mid-gather and at the handshake cover every opcode of the default table.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

  localparam int BYTE_W    = 8;
  localparam int NUM_KINDS = 10;
  localparam int INSN_LEN  = 3;

  typedef enum logic [3:0] {
    K_MOV  = 4'd0,
    K_ADD  = 4'd1,
    K_SUB  = 4'd2,
    K_JMP  = 4'd3,
    K_JZ   = 4'd4,
    K_JNZ  = 4'd5,
    K_CMPI = 4'd6,
    K_CMPR = 4'd7,
    K_MUL  = 4'd8,
    K_DIV  = 4'd9,
    K_HLT  = 4'd14,
    K_BAD  = 4'd15
  } op_kind_e;

  // Opcode for kind i sits at bits [i*8 +: 8].
  localparam logic [NUM_KINDS*BYTE_W-1:0] DEFAULT_OPMAP = {
    8'h0D, 8'h0C, 8'h09, 8'h07, 8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01
  };

  typedef enum logic [2:0] {
    ST_REQ  = 3'd0,
    ST_DATA = 3'd1,
    ST_SHOW = 3'd2,
    ST_HALT = 3'd3,
    ST_TRAP = 3'd4
  } fetch_st_e;

endpackage

// File: rtl/ifs_op_lookup.sv
module ifs_op_lookup
  import ifs_pkg::*;
#(
  parameter logic [NUM_KINDS*BYTE_W-1:0] OPMAP     = DEFAULT_OPMAP,
  parameter logic [BYTE_W-1:0]           HALT_CODE = 8'hFF
) (
  input  logic [BYTE_W-1:0] op_byte,
  output op_kind_e          kind,
  output logic              is_halt,
  output logic              is_multi
);

  logic [NUM_KINDS-1:0] hit;

  generate
    for (genvar g = 0; g < NUM_KINDS; g++) begin : g_match
      assign hit[g] = (op_byte == OPMAP[g*BYTE_W +: BYTE_W]);
    end
  endgenerate

  assign is_halt  = (op_byte == HALT_CODE);
  assign is_multi = |hit;

  always_comb begin
    kind = K_BAD;
    for (int i = 0; i < NUM_KINDS; i++) begin
      if (hit[i]) kind = op_kind_e'(i[3:0]);
    end
    if (is_halt) kind = K_HLT;
  end

endmodule

// File: rtl/ifs_pc_unit.sv
module ifs_pc_unit #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] pc
);

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (load) pc <= load_addr;
    else if (step) pc <= pc + ADDR_W'(1);
  end

endmodule

// File: rtl/ifs_insn_hold.sv
module ifs_insn_hold
  import ifs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              take,
  input  logic              cap_op,
  input  logic              cap_a,
  input  logic              cap_b,
  input  logic [BYTE_W-1:0] byte_in,
  input  op_kind_e          kind_in,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              valid,
  output logic [BYTE_W-1:0] opcode,
  output logic [BYTE_W-1:0] opa,
  output logic [BYTE_W-1:0] opb,
  output op_kind_e          kind,
  output logic [ADDR_W-1:0] ipc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      opcode <= '0;
      opa    <= '0;
      opb    <= '0;
      kind   <= K_BAD;
      ipc    <= '0;
    end else begin
      if (cap_op) begin
        opcode <= byte_in;
        kind   <= kind_in;
        ipc    <= pc_in;
      end
      if (cap_a) opa <= byte_in;
      if (cap_b) opb <= byte_in;
      if (flush || take) valid <= 1'b0;
      else if (cap_b)    valid <= 1'b1;
    end
  end

endmodule

// File: rtl/insn_fetch_seq.sv
module insn_fetch_seq
  import ifs_pkg::*;
#(
  parameter int                          ADDR_W    = 8,
  parameter logic [NUM_KINDS*BYTE_W-1:0] OPMAP     = DEFAULT_OPMAP,
  parameter logic [BYTE_W-1:0]           HALT_CODE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [7:0]        dec_opcode,
  output logic [3:0]        dec_kind,
  output logic [7:0]        dec_opa,
  output logic [7:0]        dec_opb,
  output logic [ADDR_W-1:0] dec_pc,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  output logic              halted,
  output logic              illegal
);

  localparam int IDX_W = $clog2(INSN_LEN);
  localparam logic [IDX_W-1:0] IDX_OP   = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_A    = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(INSN_LEN - 1);

  fetch_st_e        st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  logic     stopped, br_go;
  logic     step, cap_op, cap_a, cap_b, take;
  op_kind_e lk_kind, hold_kind;
  logic     lk_halt, lk_multi;

  ifs_op_lookup #(
    .OPMAP    (OPMAP),
    .HALT_CODE(HALT_CODE)
  ) u_lookup (
    .op_byte (mem_rdata),
    .kind    (lk_kind),
    .is_halt (lk_halt),
    .is_multi(lk_multi)
  );

  ifs_pc_unit #(.ADDR_W(ADDR_W)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .load     (br_go),
    .load_addr(br_target),
    .pc       (pc)
  );

  ifs_insn_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .flush  (br_go),
    .take   (take),
    .cap_op (cap_op),
    .cap_a  (cap_a),
    .cap_b  (cap_b),
    .byte_in(mem_rdata),
    .kind_in(lk_kind),
    .pc_in  (pc),
    .valid  (dec_valid),
    .opcode (dec_opcode),
    .opa    (dec_opa),
    .opb    (dec_opb),
    .kind   (hold_kind),
    .ipc    (dec_pc)
  );

  assign stopped   = (st_q == ST_HALT) || (st_q == ST_TRAP);
  assign br_go     = br_taken && !stopped;
  assign mem_rd_en = (st_q == ST_REQ);
  assign mem_addr  = pc;
  assign halted    = (st_q == ST_HALT);
  assign illegal   = (st_q == ST_TRAP);
  assign dec_kind  = hold_kind;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    step   = 1'b0;
    cap_op = 1'b0;
    cap_a  = 1'b0;
    cap_b  = 1'b0;
    take   = 1'b0;
    if (br_go) begin
      st_d  = ST_REQ;
      idx_d = IDX_OP;
    end else begin
      unique case (st_q)
        ST_REQ: st_d = ST_DATA;
        ST_DATA: begin
          step = 1'b1;
          if (idx_q == IDX_OP) begin
            if (lk_halt) begin
              st_d = ST_HALT;
            end else if (!lk_multi) begin
              st_d = ST_TRAP;
            end else begin
              cap_op = 1'b1;
              idx_d  = IDX_A;
              st_d   = ST_REQ;
            end
          end else if (idx_q == IDX_LAST) begin
            cap_b = 1'b1;
            idx_d = IDX_OP;
            st_d  = ST_SHOW;
          end else begin
            cap_a = 1'b1;
            idx_d = idx_q + IDX_W'(1);
            st_d  = ST_REQ;
          end
        end
        ST_SHOW: begin
          if (dec_ready) begin
            take = 1'b1;
            st_d = ST_REQ;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_REQ;
      idx_q <= IDX_OP;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  // Assertions next to the sequencer

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    !br_taken |=> (pc == $past(pc) || pc == $past(pc) + ADDR_W'(1)));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_ready && !br_taken) |=>
      (dec_valid && $stable(dec_opcode) && $stable(dec_opa) &&
       $stable(dec_opb) && $stable(dec_pc) && $stable(dec_kind)));

  assert_no_read_while_shown_R5: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> !mem_rd_en);

  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && !mem_rd_en && !dec_valid));

  assert_trap_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    illegal |=> (illegal && $stable(pc) && !mem_rd_en && !dec_valid));

  assert_exclusive_status_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({halted, illegal, dec_valid}));

  assert_branch_redirect_R8: assert property (@(posedge clk) disable iff (rst)
    (br_taken && !halted && !illegal) |=>
      (!dec_valid && mem_rd_en && pc == $past(br_target)));

endmodule

// File: tb/sim_insn_fetch_seq.sv
module sim_insn_fetch_seq;

  localparam int AW = 8;
  localparam int MEM_BYTES = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = 8'h00;
  logic [AW-1:0] pc;
  logic          dec_valid;
  logic          dec_ready = 1'b0;
  logic [7:0]    dec_opcode;
  logic [3:0]    dec_kind;
  logic [7:0]    dec_opa;
  logic [7:0]    dec_opb;
  logic [AW-1:0] dec_pc;
  logic          br_taken = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic          halted;
  logic          illegal;

  int vectors = 0;
  int miscompares = 0;

  logic [7:0] mem [MEM_BYTES];

  always #10 clk = ~clk;

  insn_fetch_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pc(pc),
    .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_opcode(dec_opcode), .dec_kind(dec_kind),
    .dec_opa(dec_opa), .dec_opb(dec_opb), .dec_pc(dec_pc),
    .br_taken(br_taken), .br_target(br_target),
    .halted(halted), .illegal(illegal)
  );

  // One-cycle-latency program memory
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int kind_of(input logic [7:0] b);
    case (b)
      8'h01: return 0;  8'h02: return 1;  8'h03: return 2;
      8'h04: return 3;  8'h05: return 4;  8'h06: return 5;
      8'h07: return 6;  8'h09: return 7;  8'h0C: return 8;
      8'h0D: return 9;
      default: return -1;
    endcase
  endfunction

  // Behavioural reference model
  logic [AW-1:0] m_pc, m_start, e_pc;
  logic [7:0]    got [$];
  logic [7:0]    e_op, e_a, e_b;
  bit            m_wait, m_valid, m_halt, m_ill, m_armed = 0;

  always @(posedge clk) begin
    logic [7:0] b;
    if (rst) begin
      m_pc = '0; got.delete(); m_wait = 0; m_valid = 0; m_halt = 0; m_ill = 0;
    end else if (m_halt || m_ill) begin
      // frozen
    end else if (br_taken) begin
      m_pc = br_target; got.delete(); m_valid = 0; m_wait = 0;
    end else if (m_valid) begin
      if (dec_ready) m_valid = 0;
    end else if (!m_wait) begin
      m_wait = 1;
    end else begin
      b = mem[m_pc];
      m_wait = 0;
      if (got.size() == 0) m_start = m_pc;
      m_pc = m_pc + 1'b1;
      if (got.size() == 0 && b == 8'hFF) m_halt = 1;
      else if (got.size() == 0 && kind_of(b) < 0) m_ill = 1;
      else begin
        got.push_back(b);
        if (got.size() == 3) begin
          m_valid = 1; e_op = got[0]; e_a = got[1]; e_b = got[2]; e_pc = m_start;
          got.delete();
        end
      end
    end
    m_armed = 1;
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (m_armed) begin
      bit exp_rd;
      exp_rd = !m_halt && !m_ill && !m_valid && !m_wait;
      chk(pc == m_pc, "R2 pc", pc, m_pc);
      chk(mem_rd_en == exp_rd, "R2 mem_rd_en", mem_rd_en, exp_rd);
      if (exp_rd) chk(mem_addr == m_pc, "R2 mem_addr", mem_addr, m_pc);
      chk(dec_valid == m_valid, "R5 dec_valid", dec_valid, m_valid);
      if (m_valid) begin
        chk(dec_opcode == e_op, "R3 opcode", dec_opcode, e_op);
        chk(dec_opa == e_a, "R3 opa", dec_opa, e_a);
        chk(dec_opb == e_b, "R3 opb", dec_opb, e_b);
        chk(dec_pc == e_pc, "R3 dec_pc", dec_pc, e_pc);
        chk(int'(dec_kind) == kind_of(e_op), "R4 kind", dec_kind, kind_of(e_op));
      end
      chk(halted == m_halt, "R6 halted", halted, m_halt);
      chk(illegal == m_ill, "R7 illegal", illegal, m_ill);
    end
  end

  task automatic tick(input bit rdy, input bit br, input logic [AW-1:0] tgt);
    @(negedge clk);
    dec_ready = rdy; br_taken = br; br_target = tgt;
  endtask

  task automatic do_reset();
    tick(0, 0, '0); rst = 1'b1;
    tick(0, 0, '0);
    tick(0, 0, '0); rst = 1'b0;
    // r1_ reset state, seen after the reset edges
    chk(pc == '0, "R1 pc", pc, 0);
    chk(!halted, "R1 halted", halted, 0);
    chk(!illegal, "R1 illegal", illegal, 0);
    chk(!dec_valid, "R1 dec_valid", dec_valid, 0);
  endtask

  task automatic run(input int n, input bit rnd);
    for (int i = 0; i < n; i++) tick(rnd ? 1'($urandom % 2) : 1'b1, 0, '0);
  endtask

  task automatic put3(input int a, input logic [7:0] o, input logic [7:0] x, input logic [7:0] y);
    mem[a] = o; mem[(a+1)%MEM_BYTES] = x; mem[(a+2)%MEM_BYTES] = y;
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'h00;
    // main program: every three-byte opcode, then HLT at 30
    put3(0,  8'h01, 8'h00, 8'h05);
    put3(3,  8'h0C, 8'h00, 8'h01);
    put3(6,  8'h0D, 8'h02, 8'h03);
    put3(9,  8'h07, 8'h01, 8'h09);
    put3(12, 8'h09, 8'h02, 8'h03);
    put3(15, 8'h02, 8'h01, 8'h00);
    put3(18, 8'h03, 8'h03, 8'h02);
    put3(21, 8'h04, 8'h1E, 8'h00);
    put3(24, 8'h05, 8'h10, 8'h00);
    put3(27, 8'h06, 8'hC8, 8'h00);
    mem[30] = 8'hFF;
    // trap program at 40: MOV then undefined 0x08
    put3(40, 8'h01, 8'h11, 8'h22);
    mem[43] = 8'h08;
    // wrap program: MUL spanning 254..0
    mem[254] = 8'h0C; mem[255] = 8'h01;

    // Scenario A: always-ready run to HLT
    do_reset();
    run(90, 0);
    chk(halted, "R6 halted after HLT", halted, 1);
    chk(pc == AW'(31), "R6 pc past HLT", pc, 31);
    tick(1, 1, AW'(0));
    tick(1, 0, '0);
    chk(pc == AW'(31), "R9 branch ignored when halted", pc, 31);
    chk(halted, "R9 halted kept", halted, 1);

    // Scenario B: random ready consumer
    do_reset();
    run(200, 1);
    chk(halted, "R6 halted with random ready", halted, 1);

    // Scenario C: branch mid-gather, hold-off, branch at handshake
    do_reset();
    run(3, 0);
    tick(1, 1, AW'(12));
    tick(0, 0, '0);
    chk(pc == AW'(12), "R8 pc loads target", pc, 12);
    chk(!dec_valid, "R8 partial dropped", dec_valid, 0);
    for (int i = 0; i < 20 && !dec_valid; i++) tick(0, 0, '0);
    chk(dec_valid && dec_pc == AW'(12), "R8 first insn from target", dec_pc, 12);
    run(0, 0);
    for (int i = 0; i < 4; i++) tick(0, 0, '0);
    chk(dec_valid && dec_opcode == 8'h09, "R5 held while not ready", dec_opcode, 8'h09);
    tick(1, 1, AW'(40));
    tick(1, 0, '0);
    chk(!dec_valid, "R8 presented insn dropped", dec_valid, 0);
    chk(pc == AW'(40), "R8 pc at second target", pc, 40);
    run(20, 0);
    chk(illegal, "R7 illegal raised", illegal, 1);
    chk(pc == AW'(44), "R7 pc past bad opcode", pc, 44);
    tick(1, 1, AW'(0));
    tick(1, 0, '0);
    chk(pc == AW'(44) && illegal, "R9 branch ignored when trapped", pc, 44);

    // Scenario D: wrap across the top of the address space
    do_reset();
    tick(1, 1, AW'(254));
    for (int i = 0; i < 12 && !dec_valid; i++) tick(0, 0, '0);
    chk(dec_pc == AW'(254), "R10 wrap insn address", dec_pc, 254);
    chk(dec_opb == 8'h01, "R10 byte from address 0", dec_opb, 1);
    chk(pc == AW'(1), "R10 pc wrapped", pc, 1);
    run(10, 0);
    chk(illegal && pc == AW'(2), "R10 trap after wrap", pc, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule